// File: doc/BRIEF.md
# Mode-Code Reset / In-Command Status Output

This block drives one registered, active-low status pin for a remote terminal. A function-select input chooses what the pin reports. With the select at 0 the pin frames message handling: it is low while the terminal reports that a message is being processed. With the select at 1 it becomes a short reset indication: a low pulse of a fixed number of clock cycles follows each received "reset remote terminal" mode command. The pulse is only produced while the terminal operates in RT mode. In the bus-controller-only and monitor-only modes the reset indication does nothing.

In both functions the pin is also held low while the logic self-test is busy, so the pin going high again shows that the self-test has finished. A self-test disable input set to 1 suppresses self-test. The block then ignores the busy flag. The pin comes from a flop that resets to 1, so a change of the function select cannot produce a glitch. A change of the select takes effect at the next clock edge, and any pulse in progress is dropped when the function changes.

Top module: `msg_rst_status`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status_n` is 1.
- R2: With `fn_sel` = 0, `status_n` is 0 in the cycle after an edge that samples `msg_busy` = 1. It is 1 after an edge that samples `msg_busy` = 0, unless R6 applies.
- R3: With `fn_sel` = 1 and `op_mode` = 2'b00 (RT), an edge that samples `rtrst_cmd` = 1 makes `status_n` 0 for exactly `PULSE_CYCLES` cycles (default 2). After that it returns to 1 unless R6 applies.
- R4: A reset command sampled while a pulse is running restarts the count, so the pin stays low for `PULSE_CYCLES` cycles after the latest command and no longer.
- R5: With `fn_sel` = 1 and `op_mode` equal to 2'b01 (BC-only), 2'b10 (monitor-only) or 2'b11 (reserved, treated as non-RT), `rtrst_cmd` has no effect and `status_n` stays 1 unless R6 applies.
- R6: An edge that samples `bist_busy` = 1 with `bist_off` = 0 makes `status_n` 0 in the next cycle, whatever the function and the mode.
- R7: With `bist_off` = 1, `bist_busy` has no effect on `status_n`.
- R8: At an edge where `fn_sel` differs from its value at the previous edge, the new function applies at once, any running pulse is cleared, and a reset command sampled at that edge is ignored.
- R9: With `fn_sel` = 1, `msg_busy` has no effect. With `fn_sel` = 0, `rtrst_cmd` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_sel | input | 1 | Pin function: 0 message framing, 1 reset pulse |
| op_mode | input | 2 | Operating mode: 00 RT, 01 BC-only, 10 monitor-only, 11 reserved |
| msg_busy | input | 1 | High while a message is being processed |
| rtrst_cmd | input | 1 | One-cycle strobe: reset remote terminal command received |
| bist_busy | input | 1 | High while the logic self-test runs |
| bist_off | input | 1 | Self-test disable; 1 suppresses self-test |
| status_n | output | 1 | Registered active-low status pin |

## Verification
The hardest case to reach is a reset command that lands on the same edge as a change of the function select, or in the middle of a running pulse. Such a command has to be ignored or has to restart the count, and either one shows up only as the length of a low stretch. Directed sequences toggle `fn_sel` one edge after a command and issue back-to-back commands, and the bench checks the pin on every cycle of the stretch. A sweep then steps through all 128 input combinations in two different orders. This makes the bench meet many pairs of neighbouring states, including mode and select changes during a pulse, and a cycle-by-cycle arithmetic model gives the expected value for each one.

// File: rtl/msg_rst_status_pkg.sv
package msg_rst_status_pkg;

    typedef enum logic [1:0] {
        OPM_RT       = 2'b00,
        OPM_BC_ONLY  = 2'b01,
        OPM_MON_ONLY = 2'b10,
        OPM_RESERVED = 2'b11
    } op_mode_e;

    typedef enum logic {
        FN_IN_CMD    = 1'b0,
        FN_RST_PULSE = 1'b1
    } pin_fn_e;

    typedef struct packed {
        logic bist_low;
        logic frame_low;
        logic pulse_low;
    } low_src_t;

    function automatic logic mode_is_rt(input op_mode_e m);
        return (m == OPM_RT);
    endfunction

    function automatic logic any_low(input low_src_t s, input pin_fn_e fn);
        logic fn_low;
        fn_low = (fn == FN_RST_PULSE) ? s.pulse_low : s.frame_low;
        return s.bist_low | fn_low;
    endfunction

endpackage

// File: rtl/msg_rst_pulse_gen.sv
module msg_rst_pulse_gen #(
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic trig,
    output logic pulse_next
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (!arm)
            cnt_d = '0;
        else if (trig)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign pulse_next = (cnt_d != '0);

endmodule

// File: rtl/msg_rst_low_merge.sv
module msg_rst_low_merge
    import msg_rst_status_pkg::*;
(
    input  pin_fn_e fn,
    input  logic    msg_busy,
    input  logic    pulse_next,
    input  logic    bist_busy,
    input  logic    bist_off,
    output logic    low_req
);
    low_src_t src;

    always_comb begin
        src.bist_low  = bist_busy & ~bist_off;
        src.frame_low = msg_busy;
        src.pulse_low = pulse_next;
        low_req       = any_low(src, fn);
    end

endmodule

// File: rtl/msg_rst_status.sv
module msg_rst_status
    import msg_rst_status_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fn_sel,
    input  logic [1:0] op_mode,
    input  logic       msg_busy,
    input  logic       rtrst_cmd,
    input  logic       bist_busy,
    input  logic       bist_off,
    output logic       status_n
);
    pin_fn_e  fn_now;
    pin_fn_e  fn_q;
    op_mode_e mode;
    logic     arm;
    logic     pulse_next;
    logic     low_req;

    assign fn_now = pin_fn_e'(fn_sel);
    assign mode   = op_mode_e'(op_mode);

    // previous select value, tracked through reset so a held select is not a change
    always_ff @(posedge clk) begin
        fn_q <= fn_now;
    end

    assign arm = (fn_now == FN_RST_PULSE) && mode_is_rt(mode) && (fn_q == fn_now);

    msg_rst_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .trig       (rtrst_cmd),
        .pulse_next (pulse_next)
    );

    msg_rst_low_merge u_merge (
        .fn         (fn_now),
        .msg_busy   (msg_busy),
        .pulse_next (pulse_next),
        .bist_busy  (bist_busy),
        .bist_off   (bist_off),
        .low_req    (low_req)
    );

    always_ff @(posedge clk) begin
        if (rst)
            status_n <= 1'b1;
        else
            status_n <= ~low_req;
    end

endmodule

// File: rtl/msg_rst_status_chk.sv
module msg_rst_status_chk #(
    parameter int PULSE_CYCLES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       fn_sel,
    input logic [1:0] op_mode,
    input logic       msg_busy,
    input logic       rtrst_cmd,
    input logic       bist_busy,
    input logic       bist_off,
    input logic       status_n
);
    logic bist_eff;
    assign bist_eff = bist_busy & ~bist_off;

    assert_frame_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!fn_sel && msg_busy) |=> !status_n);

    assert_frame_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!fn_sel && !msg_busy && !bist_eff) |=> status_n);

    assert_pulse_start_R3: assert property (@(posedge clk) disable iff (rst)
        (fn_sel && $stable(fn_sel) && op_mode == 2'b00 && rtrst_cmd) |=> !status_n);

    assert_non_rt_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (fn_sel && op_mode != 2'b00 && !bist_eff) |=> status_n);

    assert_selftest_low_R6: assert property (@(posedge clk) disable iff (rst)
        bist_eff |=> !status_n);

    assert_change_ignores_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        (fn_sel && $changed(fn_sel) && !bist_eff) |=> status_n);

    generate
        if (PULSE_CYCLES == 2) begin : g_len2
            assert_pulse_ends_R4: assert property (@(posedge clk) disable iff (rst)
                (fn_sel && !rtrst_cmd && !$past(rtrst_cmd) && !bist_eff) |=> status_n);
        end
    endgenerate

endmodule

bind msg_rst_status msg_rst_status_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fn_sel    (fn_sel),
    .op_mode   (op_mode),
    .msg_busy  (msg_busy),
    .rtrst_cmd (rtrst_cmd),
    .bist_busy (bist_busy),
    .bist_off  (bist_off),
    .status_n  (status_n)
);

// File: tb/msg_rst_status_test.sv
`timescale 1ns/1ps
module msg_rst_status_test;
    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fn_sel = 1'b0;
    logic [1:0] op_mode = 2'b00;
    logic       msg_busy = 1'b0;
    logic       rtrst_cmd = 1'b0;
    logic       bist_busy = 1'b0;
    logic       bist_off = 1'b0;
    logic       status_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt = 0;
    logic m_fn_prev = 1'b0;

    always #4 clk = ~clk;

    msg_rst_status #(.PULSE_CYCLES(P)) uut (
        .clk(clk), .rst(rst), .fn_sel(fn_sel), .op_mode(op_mode),
        .msg_busy(msg_busy), .rtrst_cmd(rtrst_cmd), .bist_busy(bist_busy),
        .bist_off(bist_off), .status_n(status_n)
    );

    task automatic check(input logic exp, input string tag);
        checks++;
        if (status_n !== exp) begin
            errors++;
            $display("FAIL %s: status_n=%b expected=%b at %0t", tag, status_n, exp, $time);
        end
    endtask

    // advance one edge and update the model with the inputs that edge samples
    task automatic cyc();
        logic arm;
        logic low;
        arm = fn_sel && (op_mode == 2'b00) && (fn_sel == m_fn_prev);
        if (rst) m_cnt = 0;
        else if (!arm) m_cnt = 0;
        else if (rtrst_cmd) m_cnt = P;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        m_fn_prev = fn_sel;
        low = (bist_busy && !bist_off) || (fn_sel ? (m_cnt != 0) : msg_busy);
        @(posedge clk);
        #1;
        if (!rst) begin
            if (low) m_cnt = m_cnt; // model kept in sync
        end
    endtask

    function automatic logic model_exp();
        logic low;
        low = (bist_busy && !bist_off) || (fn_sel ? (m_cnt != 0) : msg_busy);
        return rst ? 1'b1 : !low;
    endfunction

    task automatic set_in(input int k);
        fn_sel    = k[0];
        op_mode   = k[2:1];
        msg_busy  = k[3];
        rtrst_cmd = k[4];
        bist_busy = k[5];
        bist_off  = k[6];
    endtask

    task automatic idle();
        msg_busy = 0; rtrst_cmd = 0; bist_busy = 0; bist_off = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        string tag;
        // R1 reset
        repeat (3) cyc();
        check(1'b1, "R1 during reset");
        rst = 0;
        cyc();
        check(1'b1, "R1 first cycle after reset");

        // R2 framing
        fn_sel = 0; op_mode = 2'b00;
        msg_busy = 1; cyc(); check(1'b0, "R2 framing low");
        cyc(); check(1'b0, "R2 framing held");
        msg_busy = 0; cyc(); check(1'b1, "R2 framing released");
        // R9 command ignored in framing
        rtrst_cmd = 1; cyc(); rtrst_cmd = 0; check(1'b1, "R9 cmd ignored in framing");

        // R3 pulse exactly two cycles
        fn_sel = 1; cyc(); check(1'b1, "R8 change edge idle");
        rtrst_cmd = 1; cyc(); rtrst_cmd = 0; check(1'b0, "R3 pulse cycle 1");
        cyc(); check(1'b0, "R3 pulse cycle 2");
        cyc(); check(1'b1, "R3 pulse ended");
        // R9 framing input ignored in pulse mode
        msg_busy = 1; cyc(); check(1'b1, "R9 msg ignored in pulse mode");
        msg_busy = 0;

        // R4 retrigger
        rtrst_cmd = 1; cyc(); check(1'b0, "R4 first cmd");
        cyc(); rtrst_cmd = 0; check(1'b0, "R4 second cmd");
        cyc(); check(1'b0, "R4 low after latest");
        cyc(); check(1'b1, "R4 no extension");

        // R5 non-RT modes
        for (int m = 1; m < 4; m++) begin
            op_mode = 2'(m);
            rtrst_cmd = 1; cyc(); rtrst_cmd = 0;
            check(1'b1, "R5 cmd ignored non-RT");
            cyc(); check(1'b1, "R5 stays high non-RT");
        end
        op_mode = 2'b00;

        // R8 abandon pulse and ignore command on change edge
        rtrst_cmd = 1; cyc(); rtrst_cmd = 0; check(1'b0, "R8 pulse started");
        fn_sel = 0; cyc(); check(1'b1, "R8 pulse abandoned");
        fn_sel = 1; rtrst_cmd = 1; cyc(); rtrst_cmd = 0; check(1'b1, "R8 cmd on change ignored");
        cyc(); check(1'b1, "R8 still high");

        // R6 / R7 self-test
        bist_busy = 1; cyc(); check(1'b0, "R6 self-test low pulse mode");
        fn_sel = 0; cyc(); check(1'b0, "R6 self-test low framing mode");
        bist_off = 1; cyc(); check(1'b1, "R7 self-test disabled");
        bist_off = 0; bist_busy = 0; cyc(); check(1'b1, "R6 end of self-test");
        idle();

        // near-exhaustive sweeps in two orders
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 128; i++) begin
                int k;
                k = (pass == 0) ? i : ((i * 37 + 11) % 128);
                set_in(k);
                cyc();
                if (bist_busy && !bist_off) tag = "R6 sweep";
                else if (bist_busy) tag = "R7 sweep";
                else if (!fn_sel) tag = "R2 sweep";
                else if (op_mode != 2'b00) tag = "R5 sweep";
                else tag = "R3 sweep";
                check(model_exp(), tag);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule